// File: doc/BRIEF.md
# Programmable-Rate SPI Master Port

This block is a serial port that acts only as an SPI master. Software-style register writes set the frame length (4 to 16 bits), the serial clock polarity, a two-stage bit-rate divider (an even prescaler followed by an 8-bit rate divider) and an internal loopback switch. Writing a word to the transmit register starts one frame. The word is shifted out most significant bit first on `mosi` while `sck` is generated, and `miso` is sampled into a receive register.

The receive register holds the word right-justified once the frame ends. A `busy` output shows when a frame is in flight. In loopback mode the receiver takes its bits from the transmit line and ignores `miso`, so every word sent comes back unchanged. The fastest serial clock is half the port clock.

Writes go through a single write port (`wr_en`, `wr_addr`, `wr_data`). Address 0 is control word A, address 1 is control word B, address 2 is the prescaler and address 3 is the transmit register. The received word and the busy flag are driven straight onto output ports.

Top module: `spi_master_port`

## Requirements
- R1: Bits [3:0] of control word A (address 0) hold the frame length minus one. Values 3 to 15 give 4 to 16 bits, and values 0 to 2 are taken as 4 bits.
- R2: Data leaves `mosi` most significant bit first. `mosi` changes only on the trailing SCK edge of each pulse, and `miso` is sampled on the leading edge.
- R3: When `busy` falls, `rx_data` holds the received bits right-justified (the first bit received is the most significant), and every bit above the frame length is zero.
- R4: The SCK half period is P/2 × (D+1) port clock cycles. P is the prescaler byte (address 2, bits [7:0]) with bit 0 ignored, taken as 2 when it is below 2. D is bits [15:8] of control word A.
- R5: Every SCK pulse lasts its full half period, including the first pulse of a frame. The first leading edge comes one half period after the frame starts.
- R6: Bit 6 of control word A is the clock polarity. While idle, `sck` takes that level one cycle after the write.
- R7: Bit 1 of control word B (address 1) is the enable. A transmit write made while it is 0 starts nothing.
- R8: Bit 0 of control word B selects loopback. When it is set, the received word equals the transmitted word and `miso` has no effect.
- R9: `busy` rises in the cycle after an accepted transmit write and stays high for exactly 2 × N × half-period cycles, where N is the frame length in bits.
- R10: A transmit write made while `busy` is high is ignored. It starts no second frame and leaves `rx_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 ctrl A, 1 ctrl B, 2 prescaler, 3 transmit) |
| wr_data | input | 16 | Register write data |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| busy | output | 1 | Frame in progress |
| rx_data | output | 16 | Last received word, right-justified |

## Verification
A transmit write sampled on clock edge E raises `busy` right after E. The first leading SCK edge follows at E plus one half period, and `busy` and `rx_data` change together at E + 2·N·half. The idle level follows a polarity write after one more edge. The bench computes N, the half period, the expected serial word and the expected received word from the register values and queues them for each frame. A monitor samples on falling clock edges and counts the idle lead-in, the first pulse, the busy span and the bits captured on leading edges. It compares these against the queued entry at the falling edge where `busy` is first seen low. Ignored writes are judged after a fixed wait by looking at `busy` and `rx_data`.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 8;
  localparam int PS_W   = 8;
  localparam int FLEN_W = 4;
  localparam int ADDR_W = 2;
  localparam int CNT_W  = (PS_W - 1) + (DIV_W + 1);
  localparam int NB_W   = $clog2(DATA_W + 1);

  localparam logic [ADDR_W-1:0] A_CTRLA = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRLB = 2'd1;
  localparam logic [ADDR_W-1:0] A_PRESC = 2'd2;
  localparam logic [ADDR_W-1:0] A_TXD   = 2'd3;

  localparam int POL_BIT  = 6;
  localparam int EN_BIT   = 1;
  localparam int LOOP_BIT = 0;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic              cpol;
    logic [FLEN_W-1:0] flen;
    logic              en;
    logic              loop;
    logic [PS_W-2:0]   ps_half;   // prescaler with its low bit dropped
  } port_cfg_t;

  // Port clock cycles per SCK half period.
  function automatic logic [CNT_W-1:0] half_cycles(input logic [PS_W-2:0] ps_half,
                                                   input logic [DIV_W-1:0] div);
    logic [CNT_W-1:0] p;
    p = CNT_W'(ps_half);
    if (p == '0) p = CNT_W'(1);
    return p * (CNT_W'(div) + CNT_W'(1));
  endfunction

  // Bits per frame from the length field.
  function automatic logic [NB_W-1:0] frame_bits(input logic [FLEN_W-1:0] flen);
    logic [NB_W-1:0] b;
    b = NB_W'(flen) + NB_W'(1);
    if (b < NB_W'(4)) b = NB_W'(4);
    return b;
  endfunction
endpackage

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output port_cfg_t         cfg,
  output logic              tx_wr,
  output logic [DATA_W-1:0] tx_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRLA: begin
          cfg.div  <= wr_data[DATA_W-1 -: DIV_W];
          cfg.cpol <= wr_data[POL_BIT];
          cfg.flen <= wr_data[FLEN_W-1:0];
        end
        A_CTRLB: begin
          cfg.en   <= wr_data[EN_BIT];
          cfg.loop <= wr_data[LOOP_BIT];
        end
        A_PRESC: cfg.ps_half <= wr_data[PS_W-1:1];
        default: ;
      endcase
    end
  end

  assign tx_wr   = wr_en && (wr_addr == A_TXD);
  assign tx_word = wr_data;
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == half - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic [NB_W-1:0]   nbits,
  input  logic              cpol,
  input  logic              tick,
  input  logic              loop_en,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic [DATA_W-1:0] rx_word,
  output logic              sample_evt,
  output logic              shift_evt,
  output logic              frame_done
);
  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic [NB_W:0]     edge_cnt;
  logic              serial_in;

  assign mosi       = tx_sr[DATA_W-1];
  assign serial_in  = loop_en ? mosi : miso;
  assign sample_evt = busy && tick && !edge_cnt[0];
  assign shift_evt  = busy && tick &&  edge_cnt[0];
  assign frame_done = shift_evt && (edge_cnt == {nbits, 1'b0} - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0; rx_sr <= '0; edge_cnt <= '0;
      busy <= 1'b0; sck <= 1'b0; rx_word <= '0;
    end else begin
      if (!busy) sck <= cpol;
      if (load) begin
        tx_sr    <= load_word << (NB_W'(DATA_W) - nbits);
        rx_sr    <= '0;
        edge_cnt <= '0;
        busy     <= 1'b1;
      end else if (busy && tick) begin
        sck      <= ~sck;
        edge_cnt <= edge_cnt + 1'b1;
        if (sample_evt) rx_sr <= {rx_sr[DATA_W-2:0], serial_in};
        else            tx_sr <= tx_sr << 1;
        if (frame_done) begin
          busy    <= 1'b0;
          rx_word <= rx_sr;
        end
      end
    end
  end
endmodule

// File: rtl/spi_master_port.sv
module spi_master_port
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic [DATA_W-1:0] rx_data
);
  port_cfg_t         cfg;
  logic              tx_wr, load, tick;
  logic [DATA_W-1:0] tx_word;
  logic [CNT_W-1:0]  half_q;
  logic [NB_W-1:0]   nbits_q, nbits_sel;
  logic              sample_evt, shift_evt, frame_done;
  logic              cfg_cpol, cfg_en;

  assign cfg_cpol  = cfg.cpol;
  assign cfg_en    = cfg.en;
  assign load      = tx_wr && cfg.en && !busy;
  assign nbits_sel = load ? frame_bits(cfg.flen) : nbits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= CNT_W'(1);
      nbits_q <= NB_W'(4);
    end else if (load) begin
      half_q  <= half_cycles(cfg.ps_half, cfg.div);
      nbits_q <= frame_bits(cfg.flen);
    end
  end

  spi_port_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .tx_wr(tx_wr), .tx_word(tx_word)
  );

  spi_rate_gen u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half_q), .tick(tick)
  );

  spi_shift_unit u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(tx_word),
    .nbits(nbits_sel), .cpol(cfg.cpol), .tick(tick), .loop_en(cfg.loop),
    .miso(miso), .sck(sck), .mosi(mosi), .busy(busy), .rx_word(rx_data),
    .sample_evt(sample_evt), .shift_evt(shift_evt), .frame_done(frame_done)
  );
endmodule

// File: rtl/spi_port_checker.sv
module spi_port_checker
  import spi_port_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              sck,
  input logic [DATA_W-1:0] rx_data,
  input logic              cpol,
  input logic              en,
  input logic              tick,
  input logic              load,
  input logic [CNT_W-1:0]  half_q,
  input logic [NB_W-1:0]   nbits_q
);
  logic [CNT_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gap <= '0;
    else if (load || tick)    gap <= CNT_W'(1);
    else if (gap != '1)       gap <= gap + CNT_W'(1);
  end

  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap == half_q); // R5

  AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick) |-> sck != $past(sck)); // R4

  AST_SCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$past(tick)) |-> $stable(sck)); // R4

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> sck == $past(cpol)); // R6

  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en)); // R7

  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rx_data >> nbits_q) == '0); // R3
endmodule

bind spi_master_port spi_port_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sck(sck), .rx_data(rx_data),
  .cpol(cfg_cpol), .en(cfg_en), .tick(tick), .load(load),
  .half_q(half_q), .nbits_q(nbits_q)
);

// File: tb/spi_master_port_test.sv
module spi_master_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sck, mosi, busy;
  logic [15:0] rx_data;
  logic [15:0] slave_sr = '0;
  logic        miso;
  logic        cpol_tb = 1'b0;

  int checks = 0, fails = 0;
  bit ended = 0;
  logic [15:0] q_rx[$], q_tx[$];
  int          q_dur[$], q_half[$];
  logic [15:0] last_rx = '0;

  assign miso = slave_sr[15];

  always #2.5 clk = ~clk;

  spi_master_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .miso(miso), .sck(sck), .mosi(mosi),
    .busy(busy), .rx_data(rx_data)
  );

  // slave model: next bit after each trailing edge
  always @(sck) if (busy === 1'b1 && sck == cpol_tb) slave_sr = slave_sr << 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [15:0] tx, input int flen, input int ps, input int dv,
                      input bit pol, input bit lp, input logic [15:0] slv, input bit bump);
    int n, p, h;
    logic [15:0] mask;
    n = (flen < 3) ? 4 : flen + 1;
    p = ps & 'hFE;
    if (p < 2) p = 2;
    h = (p / 2) * (dv + 1);
    mask = 16'((32'h1 << n) - 1);
    cpol_tb = pol;
    wr(2'd0, {8'(dv), 1'b0, pol, 2'b00, 4'(flen)});
    wr(2'd1, {14'd0, 1'b1, lp});
    wr(2'd2, 16'(ps));
    q_tx.push_back(tx & mask);
    q_rx.push_back(lp ? (tx & mask) : 16'(slv >> (16 - n)));
    q_dur.push_back(2 * n * h);
    q_half.push_back(h);
    last_rx = lp ? (tx & mask) : 16'(slv >> (16 - n));
    slave_sr = slv;
    wr(2'd3, tx);
    if (bump) begin
      repeat (3) @(negedge clk);
      wr(2'd3, ~tx);
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: scoreboard pops one entry per finished frame
  logic pb = 1'b0, psck = 1'b0;
  int dur, lead, act, ph;
  logic [15:0] cap;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !pb) begin dur = 0; lead = 0; act = 0; ph = 0; cap = '0; end
      if (busy) begin
        dur++;
        if (sck != psck && sck != cpol_tb) cap = {cap[14:0], mosi};
        case (ph)
          0: if (sck == cpol_tb) lead++; else begin ph = 1; act = 1; end
          1: if (sck != cpol_tb) act++; else ph = 2;
          default: ;
        endcase
      end
      if (!busy && pb) begin
        if (q_rx.size() == 0) chk("R10 unexpected frame", 1, 0);
        else begin
          chk("R3 rx word", rx_data, q_rx.pop_front());
          chk("R2 mosi bits", cap, q_tx.pop_front());
          chk("R9 busy span", dur, q_dur.pop_front());
          chk("R5 first lead-in", lead, q_half[0]);
          chk("R5 R4 first pulse", act, q_half.pop_front());
        end
      end
      pb = busy; psck = sck;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset busy", busy, 0);
    chk("R6 reset sck", sck, 0);
    chk("R3 reset rx", rx_data, 0);
    // R1 R4: 8 bits, prescale 4
    send(16'h00A5, 7, 4, 0, 0, 0, 16'h3C00, 0);
    // R1: 4 bits at fastest rate
    send(16'hFFF9, 3, 2, 0, 0, 0, 16'hB000, 0);
    // R1 R6: 16 bits, polarity 1, divider 2
    send(16'hBEEF, 15, 4, 2, 1, 0, 16'h1234, 0);
    // R1 R4: field 0 means 4 bits, odd prescale 5 acts as 4
    send(16'h0013, 0, 5, 1, 0, 0, 16'hF0F0, 0);
    // R8: loopback, miso held high, prescale 0 acts as 2
    send(16'h02C6, 9, 0, 0, 1, 1, 16'hFFFF, 0);
    send(16'h5A5A, 11, 8, 0, 0, 1, 16'h0000, 0);
    // R6 idle level follows polarity
    cpol_tb = 1'b1;
    wr(2'd0, 16'h0047);
    @(negedge clk);
    chk("R6 idle high", sck, 1);
    cpol_tb = 1'b0;
    wr(2'd0, 16'h0007);
    @(negedge clk);
    chk("R6 idle low", sck, 0);
    // R7: enable clear blocks the start
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'h1234);
    seen = 0;
    repeat (20) begin @(negedge clk); if (busy) seen = 1; end
    chk("R7 no start when disabled", seen, 0);
    chk("R7 rx unchanged", rx_data, last_rx);
    // R10: write during a frame is dropped
    send(16'h00C3, 7, 6, 1, 0, 0, 16'h9900, 1);
    seen = 0;
    repeat (10) begin @(negedge clk); if (busy) seen = 1; end
    chk("R10 no second frame", seen, 0);
    chk("R10 rx kept", rx_data, last_rx);
    chk("R10 queue drained", q_rx.size(), 0);
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule